// File: doc/BRIEF.md
# Dual-Section Decade Counter

This block is a four-bit counter built from two stages. The first stage divides by two and counts falling edges of count input A. The second stage divides by five and counts falling edges of count input B. A two-bit mode input links the stages in one of three ways. In the independent arrangement the two stages run apart. In the BCD arrangement the carry out of the divide-by-two stage drives the divide-by-five stage, and the output walks 0 to 9 on edges of A. In the bi-quinary arrangement the carry out of the divide-by-five stage drives the divide-by-two stage, and bit 0 carries a square wave at one tenth of the rate of edges on B.

Each control is a pair of inputs that acts only when both of its bits are high. A clear pair forces the counter to zero. A preset pair forces it to nine, and the preset wins over the clear. All logic runs on a single system clock. The count inputs may be asynchronous. Each one passes through a synchronizer, and its falling edge becomes a one-cycle count enable.

The count inputs and the outputs are plain level signals. There is no data stream at the edge of this block, so there is no valid/ready handshake and no back-pressure.

Top module: `decade_counter`

## Requirements
- R1: While rst_n is low, q_o is 4'b0000. Bit q_o[0] is the divide-by-two stage. Bits q_o[3:1] are the divide-by-five stage, with q_o[3] as its most significant bit.
- R2: Each count input passes through SYNC_STAGES flops and then an edge detector. A rising edge on the input has no effect. A falling edge changes q_o on the third clock edge after the input goes low, when SYNC_STAGES is 2.
- R3: In independent mode (mode_i = 2'b00), each falling edge on cnt_a_i toggles q_o[0] and leaves q_o[3:1] unchanged.
- R4: In independent mode, each falling edge on cnt_b_i steps q_o[3:1] through 000, 001, 010, 011, 100 and then back to 000. q_o[0] is left unchanged.
- R5: When both bits of clr_i are high and nine_i is not 2'b11, q_o becomes 4'b0000 at the next clock edge. It stays there while the condition holds, whatever count edges arrive.
- R6: When nine_i is 2'b11, q_o becomes 4'b1001 at the next clock edge, whatever the value of clr_i. It stays there while nine_i is 2'b11, whatever count edges arrive.
- R7: Counting proceeds whenever clr_i is not 2'b11 and nine_i is not 2'b11. This covers every such combination of the four control bits.
- R8: In BCD mode (mode_i = 2'b01), falling edges on cnt_a_i step q_o through 0 to 9 in binary and then wrap to 0. Edges on cnt_b_i alone have no effect.
- R9: In BCD mode, a falling edge on cnt_b_i that coincides with a carry out of the divide-by-two stage does not add a second step. The divide-by-five stage advances exactly once.
- R10: In bi-quinary mode (mode_i = 2'b10), falling edges on cnt_b_i step the divide-by-five stage. Its wrap from 100 to 000 toggles q_o[0], so q_o[0] is low for five edges and high for five. Edges on cnt_a_i have no effect.
- R11: mode_i = 2'b11 behaves exactly as independent mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_a_i | input | 1 | Count input of the divide-by-two stage; active on its falling edge |
| cnt_b_i | input | 1 | Count input of the divide-by-five stage; active on its falling edge |
| clr_i | input | 2 | Clear pair; forces zero when both bits are high |
| nine_i | input | 2 | Preset pair; forces nine when both bits are high |
| mode_i | input | 2 | Stage linking: 00 independent, 01 BCD, 10 bi-quinary, 11 independent |
| q_o | output | 4 | Counter value: {divide-by-five stage, divide-by-two stage} |

## Verification
The bench builds the counter with its default two-flop synchronizer. This makes the three-edge latency from an input falling edge to a new output value exact, and the bench probes that latency cycle by cycle. With the default three-bit divide-by-five stage, both complete ten-state linked sequences and every clear/preset combination fit in a short run. The same configuration exercises the coincident carry-and-B case in BCD mode and the five-high, five-low pattern on bit 0.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  typedef enum logic [1:0] {
    LINK_NONE = 2'b00,
    LINK_BCD  = 2'b01,
    LINK_BQ   = 2'b10,
    LINK_ALT  = 2'b11
  } link_e;

  localparam int PENT_W = 3;
  localparam logic [PENT_W-1:0] PENT_LAST = 3'd4;
endpackage

// File: rtl/fall_detect.sv
module fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall_o
);
  logic [STAGES-1:0] sh;
  logic              last;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b0;
    else        last <= sh[STAGES-1];
  end

  assign fall_o = last & ~sh[STAGES-1];
endmodule

// File: rtl/toggle_stage.sv
module toggle_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic load_one,
  input  logic clear,
  input  logic step,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= 1'b0;
    else if (load_one) q <= 1'b1;
    else if (clear)    q <= 1'b0;
    else if (step)     q <= ~q;
  end
endmodule

// File: rtl/pent_stage.sv
module pent_stage #(
  parameter int W = 3,
  parameter logic [W-1:0] LAST = 3'd4,
  parameter logic [W-1:0] NINE_VAL = 3'd4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_nine,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (load_nine) q <= NINE_VAL;
    else if (clear)     q <= '0;
    else if (step)      q <= (q == LAST) ? '0 : q + 1'b1;
  end
endmodule

// File: rtl/decade_counter.sv
module decade_counter
  import dcnt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_a_i,
  input  logic              cnt_b_i,
  input  logic [1:0]        clr_i,
  input  logic [1:0]        nine_i,
  input  logic [1:0]        mode_i,
  output logic [PENT_W:0]   q_o
);
  logic a_fall, b_fall;
  logic set_nine, set_zero, count_en;
  logic st2_en, st5_en;
  logic qa;
  logic [PENT_W-1:0] q5;
  link_e link;

  fall_detect #(.STAGES(SYNC_STAGES)) u_a_edge (
    .clk(clk), .rst_n(rst_n), .din(cnt_a_i), .fall_o(a_fall)
  );
  fall_detect #(.STAGES(SYNC_STAGES)) u_b_edge (
    .clk(clk), .rst_n(rst_n), .din(cnt_b_i), .fall_o(b_fall)
  );

  assign set_nine = &nine_i;
  assign set_zero = (&clr_i) & ~set_nine;
  assign count_en = ~(&nine_i) & ~(&clr_i);
  assign link     = link_e'(mode_i);

  // Stage enables; carries are formed from the stepping stage's state so
  // both stages update on the same clock edge.
  always_comb begin
    st2_en = 1'b0;
    st5_en = 1'b0;
    unique case (link)
      LINK_BCD: begin
        st2_en = a_fall & count_en;
        st5_en = st2_en & qa;
      end
      LINK_BQ: begin
        st5_en = b_fall & count_en;
        st2_en = st5_en & (q5 == PENT_LAST);
      end
      default: begin
        st2_en = a_fall & count_en;
        st5_en = b_fall & count_en;
      end
    endcase
  end

  toggle_stage u_div2 (
    .clk(clk), .rst_n(rst_n), .load_one(set_nine), .clear(set_zero),
    .step(st2_en), .q(qa)
  );

  pent_stage #(.W(PENT_W), .LAST(PENT_LAST), .NINE_VAL(PENT_LAST)) u_div5 (
    .clk(clk), .rst_n(rst_n), .load_nine(set_nine), .clear(set_zero),
    .step(st5_en), .q(q5)
  );

  assign q_o = {q5, qa};
endmodule

// File: rtl/dcnt_checker.sv
module dcnt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] clr_i,
  input logic [1:0] nine_i,
  input logic [1:0] mode_i,
  input logic       a_fall,
  input logic       b_fall,
  input logic [3:0] q_o
);
  AST_NINE_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (nine_i == 2'b11) |=> (q_o == 4'b1001)); // R6

  AST_ZERO_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == 2'b11 && nine_i != 2'b11) |=> (q_o == 4'b0000)); // R5

  AST_PENT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o[3:1] <= 3'd4)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != 2'b11 && nine_i != 2'b11 && !a_fall && !b_fall) |=> $stable(q_o)); // R7

  AST_BCD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && clr_i != 2'b11 && nine_i != 2'b11 && a_fall && q_o[0])
    |=> (q_o[0] == 1'b0 &&
         q_o[3:1] == (($past(q_o[3:1]) == 3'd4) ? 3'd0 : $past(q_o[3:1]) + 3'd1))); // R9

  AST_BQ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && clr_i != 2'b11 && nine_i != 2'b11 && b_fall && q_o[3:1] == 3'd4)
    |=> (q_o[0] != $past(q_o[0]) && q_o[3:1] == 3'd0)); // R10

  AST_BQ_A_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && clr_i != 2'b11 && nine_i != 2'b11 && !b_fall) |=> $stable(q_o)); // R10
endmodule

bind decade_counter dcnt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .nine_i(nine_i), .mode_i(mode_i),
  .a_fall(a_fall), .b_fall(b_fall), .q_o(q_o)
);

// File: tb/sim_decade_counter.sv
module sim_decade_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_a = 1'b0, cnt_b = 1'b0;
  logic [1:0] clr = 2'b00, nine = 2'b00, mode = 2'b00;
  logic [3:0] q;

  typedef struct { logic [3:0] val; string tag; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0;
  logic       m_a = 1'b0;
  int         m_f = 0;
  int         hi_cnt;
  bit         done = 0;

  always #5 clk = ~clk;

  decade_counter u0 (
    .clk(clk), .rst_n(rst_n), .cnt_a_i(cnt_a), .cnt_b_i(cnt_b),
    .clr_i(clr), .nine_i(nine), .mode_i(mode), .q_o(q)
  );

  function automatic logic [3:0] model_q();
    logic [2:0] f = 3'(m_f);
    return {f, m_a};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag);
    exp_t it;
    it.val = model_q();
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic model_step(input logic a, input logic b);
    if (clr == 2'b11 || nine == 2'b11) return;
    case (mode)
      2'b01: if (a) begin
        if (m_a) m_f = (m_f + 1) % 5;
        m_a = ~m_a;
      end
      2'b10: if (b) begin
        if (m_f == 4) m_a = ~m_a;
        m_f = (m_f + 1) % 5;
      end
      default: begin
        if (a) m_a = ~m_a;
        if (b) m_f = (m_f + 1) % 5;
      end
    endcase
  endtask

  task automatic pulse(input logic a, input logic b, input string tag);
    cnt_a = a; cnt_b = b;
    tick(4);
    cnt_a = 1'b0; cnt_b = 1'b0;
    tick(5);
    model_step(a, b);
    expect_now(tag);
  endtask

  task automatic set_ctl(input logic [1:0] c, input logic [1:0] n, input string tag);
    clr = c; nine = n;
    tick(2);
    if (n == 2'b11) begin m_a = 1'b1; m_f = 4; end
    else if (c == 2'b11) begin m_a = 1'b0; m_f = 0; end
    expect_now(tag);
  endtask

  // Monitor: compares each expected item against the port value
  initial begin
    forever begin
      exp_t it;
      wait (exp_q.size() != 0);
      it = exp_q.pop_front();
      checks++;
      if (q !== it.val) begin
        fails++;
        $display("FAIL %s q=%b expected=%b", it.tag, q, it.val);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    expect_now("R1 reset value");
    tick(1);
    rst_n = 1'b1;
    tick(2);

    // R2: rise ignored, fall lands on third edge
    cnt_a = 1'b1; tick(4);
    expect_now("R2 rising edge ignored");
    tick(1);
    cnt_a = 1'b0;
    tick(2);
    expect_now("R2 no change before third edge");
    tick(1);
    m_a = 1'b1;
    expect_now("R2 change on third edge");
    tick(2);

    pulse(1'b1, 1'b0, "R3 toggle back");
    pulse(1'b1, 1'b0, "R3 toggle up");
    for (int i = 0; i < 5; i++) pulse(1'b0, 1'b1, "R4 five-step sequence");

    mode = 2'b11;
    pulse(1'b1, 1'b0, "R11 alt mode A");
    pulse(1'b0, 1'b1, "R11 alt mode B");
    mode = 2'b00;

    set_ctl(2'b00, 2'b11, "R6 preset nine");
    set_ctl(2'b11, 2'b11, "R6 preset beats clear");
    pulse(1'b1, 1'b1, "R6 hold while preset");

    set_ctl(2'b11, 2'b00, "R5 clear");
    set_ctl(2'b11, 2'b10, "R5 clear with nine 10");
    set_ctl(2'b11, 2'b01, "R5 clear with nine 01");
    pulse(1'b1, 1'b1, "R5 hold while clear");

    for (int c = 0; c < 3; c++)
      for (int n = 0; n < 3; n++) begin
        clr = 2'(c); nine = 2'(n);
        pulse(1'b0, 1'b1, "R7 counting enabled");
      end
    clr = 2'b00; nine = 2'b00;

    set_ctl(2'b11, 2'b00, "R5 clear before BCD");
    clr = 2'b00;
    mode = 2'b01;
    for (int i = 0; i < 10; i++) pulse(1'b1, 1'b0, "R8 decade sequence");
    pulse(1'b0, 1'b1, "R8 B ignored");
    pulse(1'b1, 1'b0, "R8 to one");
    pulse(1'b1, 1'b1, "R9 single step on coincident edges");

    set_ctl(2'b11, 2'b00, "R5 clear before bi-quinary");
    clr = 2'b00;
    mode = 2'b10;
    hi_cnt = 0;
    for (int i = 0; i < 10; i++) begin
      pulse(1'b0, 1'b1, "R10 bi-quinary sequence");
      if (q[0]) hi_cnt++;
    end
    checks++;
    if (hi_cnt != 5) begin
      fails++;
      $display("FAIL R10 duty high count=%0d expected=5", hi_cnt);
    end
    pulse(1'b1, 1'b0, "R10 A ignored");

    wait (exp_q.size() == 0);
    tick(1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule